// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block keeps the interrupt bookkeeping for a serial controller with two channels, A and B. Each channel holds a receive-pending flag, a transmit-pending flag and an in-service state. From these the block derives one shared interrupt line, a six-bit pending-source register and an eight-bit vector register that names the source most recently raised or cleared. Events reach it from two places. A host port performs one access per cycle: a data write, a data read or a control write carrying a three-bit command field. Each channel's receiver also pulses a flag when a byte arrives. Register pointers and bus decoding sit outside the block. Every control write that reaches it is treated as a command.

Each channel has a service state machine with four states. `SVC_IDLE` means nothing is in service. `SVC_RX` means receive is in service. `SVC_TX` means transmit is in service. `SVC_RXTX` means both are in service.
- Raising receive moves the machine from `SVC_IDLE` to `SVC_RX`, or from `SVC_TX` to `SVC_RXTX`.
- Raising transmit moves it from `SVC_IDLE` to `SVC_TX`. In `SVC_RX` and `SVC_RXTX` it only marks transmit pending.
- Clearing receive moves it from `SVC_RX` to `SVC_IDLE`, or from `SVC_RXTX` to `SVC_TX`.
- Clearing transmit moves it from `SVC_TX` to `SVC_IDLE`, or from `SVC_RXTX` to `SVC_RX`.
- The reset-highest-in-service command moves it from `SVC_RX` to `SVC_IDLE`, from `SVC_RXTX` to `SVC_TX`, or from `SVC_TX` to `SVC_IDLE`.

Any of these steps may be followed at once by a re-raise of the other source, as the requirements describe.

Top module: `sirq_vector_ctrl`

## Requirements
- R1: After reset the interrupt line is 0, the pending register is 0x00 and the vector register is 0x00.
- R2: A channel requests an interrupt when any of these holds: transmit is pending and its tx enable is 1; receive is pending and its two-bit rx mode is 01 or 10 (modes 00 and 11 do not request); its break enable and break status inputs are both 1. The line is registered and reflects an event one clock edge after the event.
- R3: The interrupt line is the OR of the two channels' requests.
- R4: The pending register bit positions are: bit 5 rx A, bit 4 tx A, bit 3 break A, bit 2 rx B, bit 1 tx B, bit 0 break B. A break bit is the registered AND of that channel's break enable and break status. An rx bit is set when a byte arrives. A tx bit is set when transmit enters service while its tx enable is 1.
- R5: With status_hi at 0 the vector codes are: rx A 0x0C, tx A 0x08, rx B 0x04, tx B 0x00, none 0x06.
- R6: With status_hi at 1 the vector codes are: rx A 0x30, tx A 0x10, rx B 0x20, tx B 0x00, none 0x60. status_hi is sampled in the cycle the vector is written.
- R7: While receive of a channel is in service, raising transmit on that channel only marks it pending. It changes neither that channel's tx pending bit nor the vector.
- R8: Command 3'b111 (reset highest in service) ends receive service if it is active, and then re-raises transmit if transmit is pending. Otherwise it ends transmit service.
- R9: Command 3'b101 (reset tx pending) clears the channel's transmit pending flag, its tx bit and transmit service, and writes the none vector. If receive is still pending, receive is raised again.
- R10: A data write raises transmit. A data read clears receive pending, its rx bit and receive service, writes the none vector, and re-raises transmit if it is pending.
- R11: In one cycle, a host access is applied to its channel before that channel's byte arrival. When both channels write the vector in the same cycle, channel A's code is kept.
- R12: Control writes with any other command code have no effect. A data read that arrives together with a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write access this cycle |
| host_rd | input | 1 | Host read access this cycle |
| host_chan | input | 1 | Channel of the access: 0 = A, 1 = B |
| host_data_sel | input | 1 | 1 = data register, 0 = control (command) |
| host_cmd | input | 3 | Command field of a control write |
| rx_byte_in | input | 2 | Byte arrived, one bit per channel (bit 0 = A) |
| status_hi | input | 1 | Selects the high vector encoding |
| tx_int_en | input | 2 | Transmit interrupt enable per channel |
| rx_int_mode | input | 2x2 | Receive interrupt mode per channel |
| brk_int_en | input | 2 | Break interrupt enable per channel |
| brk_seen | input | 2 | Break status per channel |
| irq_o | output | 1 | Shared interrupt line |
| int_pend_o | output | 6 | Pending-source register |
| int_vec_o | output | 8 | Vector register |

## Verification
Every output is due exactly one rising edge after the stimulus that causes it. The pending bits, the vector and the interrupt line all move on that same edge. The interrupt line uses the configuration that was present while the event was applied. The bench drives inputs on the falling edge and advances its reference model in that same moment. It compares all three outputs with the model on the next falling edge, which is one full edge after the stimulus. Directed steps add literal expected values at the same sampling point, covering service blocking, command behaviour and same-cycle ordering.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int CH_NUM  = 2;
    localparam int VEC_W   = 8;
    localparam int CMD_W   = 3;
    localparam int PEND_W  = 3 * CH_NUM;

    localparam logic [CMD_W-1:0] CMD_RST_TX  = 3'b101;
    localparam logic [CMD_W-1:0] CMD_RST_IUS = 3'b111;

    typedef enum logic [1:0] {
        SVC_IDLE,
        SVC_RX,
        SVC_TX,
        SVC_RXTX
    } svc_t;

    typedef enum logic [1:0] {
        VK_NONE,
        VK_RX,
        VK_TX
    } vkind_t;

    typedef struct packed {
        logic rxp;
        logic txp;
        svc_t svc;
        logic prx;
        logic ptx;
    } chan_st_t;

    typedef struct packed {
        chan_st_t st;
        logic     vwr;
        vkind_t   vk;
    } chan_step_t;

    function automatic chan_step_t f_set_rx(chan_step_t s);
        chan_step_t r;
        r = s;
        r.st.rxp = 1'b1;
        r.st.prx = 1'b1;
        r.vwr    = 1'b1;
        r.vk     = VK_RX;
        unique case (s.st.svc)
            SVC_TX, SVC_RXTX: r.st.svc = SVC_RXTX;
            default:          r.st.svc = SVC_RX;
        endcase
        return r;
    endfunction

    function automatic chan_step_t f_set_tx(chan_step_t s, logic en);
        chan_step_t r;
        r = s;
        r.st.txp = 1'b1;
        unique case (s.st.svc)
            SVC_IDLE, SVC_TX: begin
                r.st.svc = SVC_TX;
                if (en) r.st.ptx = 1'b1;
                r.vwr = 1'b1;
                r.vk  = VK_TX;
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic chan_step_t f_clr_rx(chan_step_t s, logic en);
        chan_step_t r;
        r = s;
        r.st.rxp = 1'b0;
        r.st.prx = 1'b0;
        r.vwr    = 1'b1;
        r.vk     = VK_NONE;
        unique case (s.st.svc)
            SVC_RX:   r.st.svc = SVC_IDLE;
            SVC_RXTX: r.st.svc = SVC_TX;
            default:  ;
        endcase
        if (r.st.txp) r = f_set_tx(r, en);
        return r;
    endfunction

    function automatic chan_step_t f_clr_tx(chan_step_t s);
        chan_step_t r;
        r = s;
        r.st.txp = 1'b0;
        r.st.ptx = 1'b0;
        r.vwr    = 1'b1;
        r.vk     = VK_NONE;
        unique case (s.st.svc)
            SVC_TX:   r.st.svc = SVC_IDLE;
            SVC_RXTX: r.st.svc = SVC_RX;
            default:  ;
        endcase
        if (r.st.rxp) r = f_set_rx(r);
        return r;
    endfunction

    function automatic chan_step_t f_clr_ius(chan_step_t s, logic en);
        chan_step_t r;
        r = s;
        unique case (s.st.svc)
            SVC_RX: begin
                r.st.svc = SVC_IDLE;
                if (r.st.txp) r = f_set_tx(r, en);
            end
            SVC_RXTX: begin
                r.st.svc = SVC_TX;
                if (r.st.txp) r = f_set_tx(r, en);
            end
            SVC_TX:   r.st.svc = SVC_IDLE;
            default:  ;
        endcase
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] vec_code(vkind_t k, logic is_b, logic hi);
        logic [VEC_W-1:0] v;
        unique case (k)
            VK_RX:   v = is_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
            VK_TX:   v = is_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sirq_host_dec.sv
module sirq_host_dec
    import sirq_pkg::*;
(
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_chan,
    input  logic              host_data_sel,
    input  logic [CMD_W-1:0]  host_cmd,
    output logic [CH_NUM-1:0] ev_dwr,
    output logic [CH_NUM-1:0] ev_drd,
    output logic [CH_NUM-1:0] ev_rst_tx,
    output logic [CH_NUM-1:0] ev_rst_ius
);

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        logic sel;
        assign sel           = (int'(host_chan) == c);
        assign ev_dwr[c]     = sel & host_wr & host_data_sel;
        assign ev_drd[c]     = sel & host_rd & ~host_wr & host_data_sel;
        assign ev_rst_tx[c]  = sel & host_wr & ~host_data_sel & (host_cmd == CMD_RST_TX);
        assign ev_rst_ius[c] = sel & host_wr & ~host_data_sel & (host_cmd == CMD_RST_IUS);
    end

endmodule

// File: rtl/sirq_chan.sv
module sirq_chan
    import sirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_dwr,
    input  logic       ev_drd,
    input  logic       ev_rst_tx,
    input  logic       ev_rst_ius,
    input  logic       ev_rx,
    input  logic       tx_en,
    input  logic [1:0] rx_mode,
    input  logic       brk_req,
    output logic       req_next,
    output logic       pend_rx,
    output logic       pend_tx,
    output logic       vec_wr,
    output vkind_t     vec_kind
);

    chan_st_t   cur_q;
    chan_step_t nxt;
    logic       rx_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt.st;
    end

    // next state: host access first, byte arrival second
    always_comb begin
        nxt.st  = cur_q;
        nxt.vwr = 1'b0;
        nxt.vk  = VK_NONE;
        if (ev_dwr)          nxt = f_set_tx(nxt, tx_en);
        else if (ev_drd)     nxt = f_clr_rx(nxt, tx_en);
        else if (ev_rst_tx)  nxt = f_clr_tx(nxt);
        else if (ev_rst_ius) nxt = f_clr_ius(nxt, tx_en);
        if (ev_rx)           nxt = f_set_rx(nxt);
    end

    // outputs
    assign rx_en    = (rx_mode == 2'b01) || (rx_mode == 2'b10);
    assign req_next = (tx_en & nxt.st.txp) | (rx_en & nxt.st.rxp) | brk_req;
    assign pend_rx  = cur_q.prx;
    assign pend_tx  = cur_q.ptx;
    assign vec_wr   = nxt.vwr;
    assign vec_kind = nxt.vk;

endmodule

// File: rtl/sirq_out.sv
module sirq_out
    import sirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_hi,
    input  logic [CH_NUM-1:0] vec_wr,
    input  vkind_t            vec_kind [CH_NUM],
    input  logic [CH_NUM-1:0] req_next,
    input  logic [CH_NUM-1:0] brk_req,
    output logic              irq_q,
    output logic [CH_NUM-1:0] ext_q,
    output logic [VEC_W-1:0]  vec_q
);

    logic [VEC_W-1:0] vec_d;

    // lower channel index is applied last and so wins
    always_comb begin
        vec_d = vec_q;
        for (int c = CH_NUM - 1; c >= 0; c--) begin
            if (vec_wr[c]) vec_d = vec_code(vec_kind[c], (c != 0), status_hi);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            ext_q <= '0;
            vec_q <= '0;
        end else begin
            irq_q <= |req_next;
            ext_q <= brk_req;
            vec_q <= vec_d;
        end
    end

endmodule

// File: rtl/sirq_vector_ctrl.sv
module sirq_vector_ctrl
    import sirq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic                   host_chan,
    input  logic                   host_data_sel,
    input  logic [CMD_W-1:0]       host_cmd,
    input  logic [CH_NUM-1:0]      rx_byte_in,
    input  logic                   status_hi,
    input  logic [CH_NUM-1:0]      tx_int_en,
    input  logic [CH_NUM-1:0][1:0] rx_int_mode,
    input  logic [CH_NUM-1:0]      brk_int_en,
    input  logic [CH_NUM-1:0]      brk_seen,
    output logic                   irq_o,
    output logic [PEND_W-1:0]      int_pend_o,
    output logic [VEC_W-1:0]       int_vec_o
);

    logic [CH_NUM-1:0] ev_dwr, ev_drd, ev_rst_tx, ev_rst_ius;
    logic [CH_NUM-1:0] req_next, pend_rx, pend_tx, vec_wr, brk_req, ext_q;
    vkind_t            vec_kind [CH_NUM];

    sirq_host_dec dec_i (
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_chan     (host_chan),
        .host_data_sel (host_data_sel),
        .host_cmd      (host_cmd),
        .ev_dwr        (ev_dwr),
        .ev_drd        (ev_drd),
        .ev_rst_tx     (ev_rst_tx),
        .ev_rst_ius    (ev_rst_ius)
    );

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        assign brk_req[c] = brk_int_en[c] & brk_seen[c];

        sirq_chan chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev_dwr     (ev_dwr[c]),
            .ev_drd     (ev_drd[c]),
            .ev_rst_tx  (ev_rst_tx[c]),
            .ev_rst_ius (ev_rst_ius[c]),
            .ev_rx      (rx_byte_in[c]),
            .tx_en      (tx_int_en[c]),
            .rx_mode    (rx_int_mode[c]),
            .brk_req    (brk_req[c]),
            .req_next   (req_next[c]),
            .pend_rx    (pend_rx[c]),
            .pend_tx    (pend_tx[c]),
            .vec_wr     (vec_wr[c]),
            .vec_kind   (vec_kind[c])
        );

        assign int_pend_o[3*(CH_NUM-1-c) +: 3] = {pend_rx[c], pend_tx[c], ext_q[c]};
    end

    sirq_out out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_hi (status_hi),
        .vec_wr    (vec_wr),
        .vec_kind  (vec_kind),
        .req_next  (req_next),
        .brk_req   (brk_req),
        .irq_q     (irq_o),
        .ext_q     (ext_q),
        .vec_q     (int_vec_o)
    );

endmodule

// File: rtl/sirq_chk.sv
module sirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic       host_chan,
    input logic       host_data_sel,
    input logic [2:0] host_cmd,
    input logic [1:0] rx_byte_in,
    input logic [1:0] tx_int_en,
    input logic [3:0] rx_int_mode,
    input logic [1:0] brk_int_en,
    input logic [1:0] brk_seen,
    input logic       irq_o,
    input logic [5:0] int_pend_o,
    input logic [7:0] int_vec_o
);

    // R2
    irq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !host_wr && !host_rd && rx_byte_in == 2'b00 &&
         $stable(tx_int_en) && $stable(rx_int_mode) &&
         $stable(brk_int_en) && $stable(brk_seen)) |=> $stable(irq_o));

    // R5 R6
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_vec_o inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C,
                          8'h10, 8'h20, 8'h30, 8'h60});

    // R4
    rx_a_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_pend_o[5]) |-> $past(rx_byte_in[0]));

    // R9
    rst_tx_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_data_sel && host_chan && host_cmd == 3'b101)
        |=> !int_pend_o[1]);

    // R10
    read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_data_sel && !host_chan && !rx_byte_in[0])
        |=> !int_pend_o[5]);

endmodule

bind sirq_vector_ctrl sirq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_chan     (host_chan),
    .host_data_sel (host_data_sel),
    .host_cmd      (host_cmd),
    .rx_byte_in    (rx_byte_in),
    .tx_int_en     (tx_int_en),
    .rx_int_mode   (rx_int_mode),
    .brk_int_en    (brk_int_en),
    .brk_seen      (brk_seen),
    .irq_o         (irq_o),
    .int_pend_o    (int_pend_o),
    .int_vec_o     (int_vec_o)
);

// File: tb/sirq_vector_ctrl_tb_top.sv
module sirq_vector_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic            rst_n = 1'b0;
    logic            host_wr = 0, host_rd = 0, host_chan = 0, host_data_sel = 0;
    logic [2:0]      host_cmd = 0;
    logic [1:0]      rx_byte_in = 0;
    logic            status_hi = 0;
    logic [1:0]      tx_int_en = 0;
    logic [1:0][1:0] rx_int_mode = 0;
    logic [1:0]      brk_int_en = 0, brk_seen = 0;
    logic            irq_o;
    logic [5:0]      int_pend_o;
    logic [7:0]      int_vec_o;

    sirq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_chan(host_chan), .host_data_sel(host_data_sel), .host_cmd(host_cmd),
        .rx_byte_in(rx_byte_in), .status_hi(status_hi), .tx_int_en(tx_int_en),
        .rx_int_mode(rx_int_mode), .brk_int_en(brk_int_en), .brk_seen(brk_seen),
        .irq_o(irq_o), .int_pend_o(int_pend_o), .int_vec_o(int_vec_o)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model, index 0 = channel A, 1 = channel B
    bit m_rxp[2], m_txp[2], m_rxs[2], m_txs[2], m_prx[2], m_ptx[2], m_ext[2];
    logic [7:0] m_vec;
    bit m_irq;

    function automatic logic [7:0] vcode(int kind, int ch);
        if (kind == 1) return (ch == 0) ? (status_hi ? 8'h30 : 8'h0C) : (status_hi ? 8'h20 : 8'h04);
        if (kind == 2) return (ch == 0) ? (status_hi ? 8'h10 : 8'h08) : 8'h00;
        return status_hi ? 8'h60 : 8'h06;
    endfunction

    function automatic void m_set_rx(int ch);
        m_rxp[ch] = 1; m_rxs[ch] = 1; m_prx[ch] = 1;
        m_vec = vcode(1, ch);
    endfunction

    function automatic void m_set_tx(int ch);
        m_txp[ch] = 1;
        if (!m_rxs[ch]) begin
            m_txs[ch] = 1;
            if (tx_int_en[ch]) m_ptx[ch] = 1;
            m_vec = vcode(2, ch);
        end
    endfunction

    function automatic void m_clr_rx(int ch);
        m_rxp[ch] = 0; m_rxs[ch] = 0; m_prx[ch] = 0;
        m_vec = vcode(0, ch);
        if (m_txp[ch]) m_set_tx(ch);
    endfunction

    function automatic void m_clr_tx(int ch);
        m_txp[ch] = 0; m_txs[ch] = 0; m_ptx[ch] = 0;
        m_vec = vcode(0, ch);
        if (m_rxp[ch]) m_set_rx(ch);
    endfunction

    function automatic void m_clr_ius(int ch);
        if (m_rxs[ch]) begin
            m_rxs[ch] = 0;
            if (m_txp[ch]) m_set_tx(ch);
        end else if (m_txs[ch]) begin
            m_txs[ch] = 0;
        end
    endfunction

    function automatic void model_update();
        m_irq = 0;
        for (int ch = 1; ch >= 0; ch--) begin
            if (int'(host_chan) == ch) begin
                if (host_wr && host_data_sel) m_set_tx(ch);
                else if (host_rd && !host_wr && host_data_sel) m_clr_rx(ch);
                else if (host_wr && !host_data_sel && host_cmd == 3'b101) m_clr_tx(ch);
                else if (host_wr && !host_data_sel && host_cmd == 3'b111) m_clr_ius(ch);
            end
            if (rx_byte_in[ch]) m_set_rx(ch);
            m_ext[ch] = brk_int_en[ch] && brk_seen[ch];
        end
        for (int ch = 0; ch < 2; ch++) begin
            if ((tx_int_en[ch] && m_txp[ch]) ||
                ((rx_int_mode[ch] == 2'b01 || rx_int_mode[ch] == 2'b10) && m_rxp[ch]) ||
                m_ext[ch]) m_irq = 1;
        end
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk("R2 R3 irq", {7'd0, irq_o}, {7'd0, m_irq});
        chk("R4 pending", {2'b00, int_pend_o},
            {2'b00, m_prx[0], m_ptx[0], m_ext[0], m_prx[1], m_ptx[1], m_ext[1]});
        chk("R5 R6 vector", int_vec_o, m_vec);
    endtask

    // drive at the falling edge, compare at the next falling edge
    task automatic step(input bit wr, input bit rd, input bit ch, input bit dsel,
                        input logic [2:0] cmd, input logic [1:0] rx);
        host_wr = wr; host_rd = rd; host_chan = ch; host_data_sel = dsel;
        host_cmd = cmd; rx_byte_in = rx;
        model_update();
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 3'd0, 2'b00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < 2; ch++) begin
            m_rxp[ch] = 0; m_txp[ch] = 0; m_rxs[ch] = 0; m_txs[ch] = 0;
            m_prx[ch] = 0; m_ptx[ch] = 0; m_ext[ch] = 0;
        end
        m_vec = 8'h00; m_irq = 0;
        tx_int_en = 2'b11;
        rx_int_mode[0] = 2'b01; rx_int_mode[1] = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        chk("R1 pending", {2'b00, int_pend_o}, 8'h00);
        chk("R1 vector", int_vec_o, 8'h00);

        step(0, 0, 0, 0, 3'd0, 2'b01);            // byte on A
        chk("R5 rx A vector", int_vec_o, 8'h0C);
        chk("R4 rx A bit", {2'b00, int_pend_o}, 8'h20);
        chk("R2 rx request", {7'd0, irq_o}, 8'h01);

        step(1, 0, 0, 1, 3'd0, 2'b00);            // data write A while rx in service
        chk("R7 blocked vector", int_vec_o, 8'h0C);
        chk("R7 blocked pending", {2'b00, int_pend_o}, 8'h20);

        step(1, 0, 0, 0, 3'b010, 2'b00);          // unrelated command
        chk("R12 other cmd vector", int_vec_o, 8'h0C);
        chk("R12 other cmd pending", {2'b00, int_pend_o}, 8'h20);

        step(1, 0, 0, 0, 3'b111, 2'b00);          // reset highest in service
        chk("R8 tx re-raised vector", int_vec_o, 8'h08);
        chk("R8 tx bit", {2'b00, int_pend_o}, 8'h30);

        step(0, 1, 0, 1, 3'd0, 2'b00);            // data read A
        chk("R10 read vector", int_vec_o, 8'h08);
        chk("R10 read pending", {2'b00, int_pend_o}, 8'h10);

        step(1, 0, 0, 0, 3'b101, 2'b00);          // reset tx pending
        chk("R9 none vector", int_vec_o, 8'h06);
        chk("R9 pending", {2'b00, int_pend_o}, 8'h00);
        chk("R9 irq", {7'd0, irq_o}, 8'h00);

        status_hi = 1'b1;
        step(0, 0, 0, 0, 3'd0, 2'b10);            // byte on B
        chk("R6 rx B vector", int_vec_o, 8'h20);
        chk("R6 rx B pending", {2'b00, int_pend_o}, 8'h04);

        rx_int_mode[1] = 2'b11;
        idle();
        chk("R2 mode 11 no request", {7'd0, irq_o}, 8'h00);

        step(0, 1, 1, 1, 3'd0, 2'b01);            // read B and byte on A together
        chk("R11 A vector wins", int_vec_o, 8'h30);
        chk("R11 pending", {2'b00, int_pend_o}, 8'h20);

        step(0, 1, 0, 1, 3'd0, 2'b01);            // read A then byte A same cycle
        chk("R11 host before rx", {2'b00, int_pend_o}, 8'h20);

        rx_int_mode[0] = 2'b00; rx_int_mode[1] = 2'b00;
        brk_int_en[1] = 1'b1; brk_seen[1] = 1'b1;
        idle();
        chk("R3 break B irq", {7'd0, irq_o}, 8'h01);
        chk("R4 break B bit", {2'b00, int_pend_o}, 8'h21);
        brk_seen[1] = 1'b0;
        idle();
        chk("R3 no source", {7'd0, irq_o}, 8'h00);

        for (int i = 0; i < 6000; i++) begin
            int op;
            bit c;
            logic [2:0] cmd;
            if ($urandom_range(0, 15) == 0) begin
                status_hi   = 1'($urandom);
                tx_int_en   = 2'($urandom);
                rx_int_mode = 4'($urandom);
                brk_int_en  = 2'($urandom);
                brk_seen    = 2'($urandom);
            end
            op  = $urandom_range(0, 9);
            c   = 1'($urandom);
            cmd = ($urandom_range(0, 3) == 0) ? 3'($urandom) :
                  (($urandom_range(0, 1) == 0) ? 3'b101 : 3'b111);
            case (op)
                0, 1:    step(1, 0, c, 1, 3'd0, 2'($urandom_range(0, 3) == 0 ? $urandom : 0));
                2, 3:    step(0, 1, c, 1, 3'd0, 2'($urandom_range(0, 3) == 0 ? $urandom : 0));
                4, 5:    step(1, 0, c, 0, cmd, 2'($urandom_range(0, 3) == 0 ? $urandom : 0));
                6, 7:    step(0, 0, c, 0, 3'd0, 2'($urandom));
                default: idle();
            endcase
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule